// File: doc/BRIEF.md
# Display-Identification RAM with Checksum Engine and Per-Port Read Overlay

This block stores one 256-byte display-identification image that is split into 128-byte blocks. Every block ends with a checksum byte. After reset a sequencer fills the whole RAM with zeros and only then raises `ready`. `ready` is the condition under which the surrounding logic may allow a hot-plug indication. A host port reads and writes the raw image.

A one-cycle pulse on `csum_start` starts a serial engine. The engine walks the image one byte per clock and writes each block's checksum into that block's last byte.

A read-only port for the display data channel serves several sink ports from the same image. For the selected port it returns that port's 16-bit physical address at a programmable byte location, `paddr_loc`, and at the following byte. At the checksum byte of the block that holds that location, it returns a checksum for that port. The engine computes this per-port checksum during its walk, using the substituted address bytes. With this overlay every port sees a consistent block without storing a separate copy of the image.

Top module: `edid_ram_ctrl`

## Requirements
- R1: After reset release, the block writes zero into every RAM byte and raises `ready` within 260 clock cycles. `ready` then stays high until the next reset.
- R2: A host write is discarded while `ready` is low or `csum_busy` is high. Reading the same address later returns the earlier content.
- R3: A host read returns the stored byte with no substitution. `host_rvalid` is high, and `host_rdata` holds the byte, in the cycle after the cycle in which `host_rd` was sampled.
- R4: When `csum_start` is sampled high while `ready` is high and the engine is idle:
  - `csum_busy` rises on the next cycle and stays high for exactly 256 cycles, covering one byte per clock.
  - `csum_done` pulses for exactly one cycle, in the cycle in which `csum_busy` falls.
- R5: A `csum_start` pulse that arrives while `csum_busy` is high is ignored. It neither restarts nor extends the run, and it produces no extra `csum_done`.
- R6: After a run, the byte at offset 0x7F of each 128-byte block holds (0 − sum of the block's bytes at offsets 0x00–0x7E) mod 256. As a result, all 128 bytes of the block sum to zero mod 256.
- R7: A data-channel read returns the RAM byte at `ddc_addr` when no overlay applies. `ddc_rvalid` is high, and `ddc_rdata` holds the byte, in the cycle after `ddc_rd` was sampled.
- R8: When `paddr_loc` is above 0x7F, a data-channel read overlays the selected port's physical address:
  - At `paddr_loc` it returns bits [15:8], that is field A in [15:12] and field B in [11:8].
  - At `paddr_loc`+1 it returns bits [7:0], that is field C in [7:4] and field D in [3:0].
  - It ignores the RAM content at those two addresses.
- R9: When `paddr_loc` is above 0x7F, a data-channel read of the checksum byte of the block that contains `paddr_loc` (address `paddr_loc` with bits [6:0] forced to 1) returns the selected port's own checksum. The most recent run computed that checksum over the block with the port's two address bytes substituted.
- R10: When `paddr_loc` is 0x7F or below, no overlay takes place. Data-channel reads at that location, at the following byte and at any checksum byte return the raw RAM content.
- R11: `ddc_port` selects which port's address and checksum the overlay uses. Port p takes its address from `port_paddr[16p+15:16p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_we | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| host_rvalid | output | 1 | Host read data valid |
| csum_start | input | 1 | Pulse that starts a checksum run |
| csum_busy | output | 1 | Checksum run in progress |
| csum_done | output | 1 | One-cycle pulse at the end of a run |
| ready | output | 1 | RAM cleared; hot-plug may be indicated |
| paddr_loc | input | ADDR_W | Byte location of the physical address overlay |
| port_paddr | input | 16*NUM_PORTS | Physical address of each port, port 0 in the low bits |
| ddc_rd | input | 1 | Data-channel read strobe |
| ddc_addr | input | ADDR_W | Data-channel byte address |
| ddc_port | input | PORT_W | Port on whose behalf the read is made |
| ddc_rdata | output | 8 | Data-channel read byte, registered |
| ddc_rvalid | output | 1 | Data-channel read data valid |

## Verification
The overlay properties assume that `paddr_loc` never points at the last two bytes of a block, so that both address bytes and the block's checksum byte are distinct. They also assume that `paddr_loc` and `port_paddr` are held steady while a run is in progress. The stimulus uses only block-interior locations, 0x9A and the block boundary 0x80. It changes the location and the port addresses only while the engine is idle. The bench also keeps host and data-channel strobes low during reset, so the registered-valid properties see a clean first cycle.

// File: rtl/edid_pkg.sv
package edid_pkg;
  // log2 of the block size in bytes; the last byte of each block holds its checksum
  localparam int BLK_OFF_W = 7;
  // width of one port's physical address
  localparam int PADDR_W   = 16;

  // two's complement of a byte sum: the value that zeroes the block total
  function automatic logic [7:0] neg_byte(input logic [7:0] v);
    return 8'(8'd0 - v);
  endfunction
endpackage

// File: rtl/edid_clear_seq.sv
module edid_clear_seq #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              clr_we,
  output logic [ADDR_W-1:0] clr_addr,
  output logic              clr_ready
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic              active_q, active_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (active_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign clr_we    = active_q;
  assign clr_addr  = cnt_q;
  assign clr_ready = ~active_q;
endmodule

// File: rtl/edid_csum_engine.sv
module edid_csum_engine
  import edid_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         enable,
  input  logic [ADDR_W-1:0]            loc,
  input  logic [NUM_PORTS*PADDR_W-1:0] port_paddr,
  input  logic [7:0]                   rdata,
  output logic [ADDR_W-1:0]            raddr,
  output logic                         we,
  output logic [ADDR_W-1:0]            waddr,
  output logic [7:0]                   wdata,
  output logic                         busy,
  output logic                         done,
  output logic [NUM_PORTS*8-1:0]       port_csum
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [7:0]        sum_q, sum_d;
  logic [7:0]        patch_q, patch_d;

  logic              is_slot, loc_ok, blk_match, hit, cap;
  logic [ADDR_W-1:0] loc_nxt;

  assign is_slot   = &cnt_q[BLK_OFF_W-1:0];
  assign loc_ok    = |loc[ADDR_W-1:BLK_OFF_W];
  assign loc_nxt   = loc + 1'b1;
  assign blk_match = (cnt_q[ADDR_W-1:BLK_OFF_W] == loc[ADDR_W-1:BLK_OFF_W]);
  assign hit       = loc_ok && ((cnt_q == loc) || (cnt_q == loc_nxt));
  assign cap       = busy_q && is_slot && loc_ok && blk_match;

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    cnt_d   = cnt_q;
    sum_d   = sum_q;
    patch_d = patch_q;
    if (!busy_q) begin
      if (start && enable) begin
        busy_d  = 1'b1;
        cnt_d   = '0;
        sum_d   = '0;
        patch_d = '0;
      end
    end else begin
      if (is_slot) begin
        sum_d   = '0;
        patch_d = '0;
      end else begin
        sum_d = sum_q + rdata;
        if (hit) patch_d = patch_q + rdata;
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      sum_q   <= '0;
      patch_q <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
      sum_q   <= sum_d;
      patch_q <= patch_d;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [7:0] hi, lo, pc_q, pc_d;
    assign hi = port_paddr[p*PADDR_W+8 +: 8];
    assign lo = port_paddr[p*PADDR_W +: 8];

    always_comb begin
      pc_d = pc_q;
      if (cap) pc_d = neg_byte(sum_q - patch_q + hi + lo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
    end

    assign port_csum[p*8 +: 8] = pc_q;
  end

  assign raddr = cnt_q;
  assign waddr = cnt_q;
  assign we    = busy_q && is_slot;
  assign wdata = neg_byte(sum_q);
  assign busy  = busy_q;
  assign done  = done_q;
endmodule

// File: rtl/edid_ddc_mux.sv
module edid_ddc_mux
  import edid_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 2,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [PORT_W-1:0]            port,
  input  logic [ADDR_W-1:0]            loc,
  input  logic [NUM_PORTS*PADDR_W-1:0] port_paddr,
  input  logic [NUM_PORTS*8-1:0]       port_csum,
  input  logic [7:0]                   ram_byte,
  output logic [7:0]                   rdata,
  output logic                         rvalid
);
  logic              loc_ok;
  logic [ADDR_W-1:0] loc_nxt, csum_addr;
  logic [15:0]       sel_pa;
  logic [7:0]        sel_pc;
  logic [7:0]        byte_d, rdata_q, rdata_d;
  logic              rvalid_q;

  assign loc_ok    = |loc[ADDR_W-1:BLK_OFF_W];
  assign loc_nxt   = loc + 1'b1;
  assign csum_addr = {loc[ADDR_W-1:BLK_OFF_W], {BLK_OFF_W{1'b1}}};
  assign sel_pa    = port_paddr[int'(port)*PADDR_W +: PADDR_W];
  assign sel_pc    = port_csum[int'(port)*8 +: 8];

  always_comb begin
    byte_d = ram_byte;
    if (loc_ok) begin
      if (addr == loc)            byte_d = sel_pa[15:8];
      else if (addr == loc_nxt)   byte_d = sel_pa[7:0];
      else if (addr == csum_addr) byte_d = sel_pc;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd) rdata_d = byte_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rd;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/edid_ram_ctrl.sv
module edid_ram_ctrl
  import edid_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 2,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_we,
  input  logic                         host_rd,
  input  logic [ADDR_W-1:0]            host_addr,
  input  logic [7:0]                   host_wdata,
  output logic [7:0]                   host_rdata,
  output logic                         host_rvalid,
  input  logic                         csum_start,
  output logic                         csum_busy,
  output logic                         csum_done,
  output logic                         ready,
  input  logic [ADDR_W-1:0]            paddr_loc,
  input  logic [NUM_PORTS*PADDR_W-1:0] port_paddr,
  input  logic                         ddc_rd,
  input  logic [ADDR_W-1:0]            ddc_addr,
  input  logic [PORT_W-1:0]            ddc_port,
  output logic [7:0]                   ddc_rdata,
  output logic                         ddc_rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              clr_we, clr_ready;
  logic [ADDR_W-1:0] clr_addr;

  edid_clear_seq #(.ADDR_W(ADDR_W)) u_clear (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_we    (clr_we),
    .clr_addr  (clr_addr),
    .clr_ready (clr_ready)
  );

  logic                   eng_we, eng_busy, eng_done;
  logic [ADDR_W-1:0]      eng_raddr, eng_waddr;
  logic [7:0]             eng_wdata, eng_rdata;
  logic [NUM_PORTS*8-1:0] port_csum;

  edid_csum_engine #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_engine (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (csum_start),
    .enable     (clr_ready),
    .loc        (paddr_loc),
    .port_paddr (port_paddr),
    .rdata      (eng_rdata),
    .raddr      (eng_raddr),
    .we         (eng_we),
    .waddr      (eng_waddr),
    .wdata      (eng_wdata),
    .busy       (eng_busy),
    .done       (eng_done),
    .port_csum  (port_csum)
  );

  // RAM write port: clear sequencer, then engine, then host
  logic [7:0]        mem [DEPTH];
  logic              host_acc, ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [7:0]        ram_wdata;

  assign host_acc = host_we && clr_ready && !eng_busy;

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = host_addr;
    ram_wdata = host_wdata;
    if (clr_we) begin
      ram_we    = 1'b1;
      ram_waddr = clr_addr;
      ram_wdata = '0;
    end else if (eng_we) begin
      ram_we    = 1'b1;
      ram_waddr = eng_waddr;
      ram_wdata = eng_wdata;
    end else if (host_acc) begin
      ram_we    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_waddr] <= ram_wdata;
  end

  assign eng_rdata = mem[eng_raddr];

  // host read path, raw content
  logic [7:0] hrd_q, hrd_d;
  logic       hvalid_q;

  always_comb begin
    hrd_d = hrd_q;
    if (host_rd) hrd_d = mem[host_addr];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hrd_q    <= '0;
      hvalid_q <= 1'b0;
    end else begin
      hrd_q    <= hrd_d;
      hvalid_q <= host_rd;
    end
  end

  assign host_rdata  = hrd_q;
  assign host_rvalid = hvalid_q;

  // data-channel read path with per-port overlay
  edid_ddc_mux #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_ddc (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd         (ddc_rd),
    .addr       (ddc_addr),
    .port       (ddc_port),
    .loc        (paddr_loc),
    .port_paddr (port_paddr),
    .port_csum  (port_csum),
    .ram_byte   (mem[ddc_addr]),
    .rdata      (ddc_rdata),
    .rvalid     (ddc_rvalid)
  );

  assign csum_busy = eng_busy;
  assign csum_done = eng_done;
  assign ready     = clr_ready;
endmodule

// File: rtl/edid_ram_ctrl_chk.sv
module edid_ram_ctrl_chk #(
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 2,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    host_rd,
  input logic                    host_rvalid,
  input logic                    csum_start,
  input logic                    csum_busy,
  input logic                    csum_done,
  input logic                    ready,
  input logic [ADDR_W-1:0]       paddr_loc,
  input logic [NUM_PORTS*16-1:0] port_paddr,
  input logic                    ddc_rd,
  input logic [ADDR_W-1:0]       ddc_addr,
  input logic [PORT_W-1:0]       ddc_port,
  input logic [7:0]              ddc_rdata,
  input logic                    ddc_rvalid
);
  logic              loc_ok;
  logic [ADDR_W-1:0] loc_nxt;
  logic [15:0]       sel_pa;

  assign loc_ok  = |paddr_loc[ADDR_W-1:7];
  assign loc_nxt = paddr_loc + 1'b1;
  assign sel_pa  = port_paddr[int'(ddc_port)*16 +: 16];

  p_ready_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  p_host_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

  p_busy_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    csum_busy |-> ready);

  p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csum_busy) |-> csum_done);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    csum_done |=> !csum_done);

  p_start_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csum_busy) |-> $past(csum_start));

  p_ddc_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ddc_rd |=> ddc_rvalid);

  p_sub_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ddc_rd && loc_ok && ddc_addr == paddr_loc) |=> (ddc_rdata == $past(sel_pa[15:8])));

  p_sub_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ddc_rd && loc_ok && ddc_addr == loc_nxt) |=> (ddc_rdata == $past(sel_pa[7:0])));
endmodule

bind edid_ram_ctrl edid_ram_ctrl_chk #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_rd     (host_rd),
  .host_rvalid (host_rvalid),
  .csum_start  (csum_start),
  .csum_busy   (csum_busy),
  .csum_done   (csum_done),
  .ready       (ready),
  .paddr_loc   (paddr_loc),
  .port_paddr  (port_paddr),
  .ddc_rd      (ddc_rd),
  .ddc_addr    (ddc_addr),
  .ddc_port    (ddc_port),
  .ddc_rdata   (ddc_rdata),
  .ddc_rvalid  (ddc_rvalid)
);

// File: tb/sim_edid_ram_ctrl.sv
`timescale 1ns/1ps
module sim_edid_ram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we, host_rd, csum_start, ddc_rd;
  logic [7:0]  host_addr, host_wdata, paddr_loc, ddc_addr;
  logic [31:0] port_paddr;
  logic [0:0]  ddc_port;
  logic [7:0]  host_rdata, ddc_rdata;
  logic        host_rvalid, ddc_rvalid, csum_busy, csum_done, ready;

  always #2 clk = ~clk;

  edid_ram_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .csum_start(csum_start), .csum_busy(csum_busy), .csum_done(csum_done),
    .ready(ready), .paddr_loc(paddr_loc), .port_paddr(port_paddr),
    .ddc_rd(ddc_rd), .ddc_addr(ddc_addr), .ddc_port(ddc_port),
    .ddc_rdata(ddc_rdata), .ddc_rvalid(ddc_rvalid)
  );

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;
  logic [7:0] bmem [256];
  logic [7:0] pcs [2];

  logic [7:0] h_exp[$];
  string      h_tag[$];
  logic [7:0] d_exp[$];
  string      d_tag[$];
  int busy_cyc = 0;
  int done_cnt = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // monitors: pop the scoreboard when results appear
  always @(negedge clk) begin
    if (host_rvalid) begin
      if (h_exp.size() == 0) chk("R3 unexpected host data", 1, 0);
      else chk(h_tag.pop_front(), {24'd0, host_rdata}, {24'd0, h_exp.pop_front()});
    end
    if (ddc_rvalid) begin
      if (d_exp.size() == 0) chk("R7 unexpected ddc data", 1, 0);
      else chk(d_tag.pop_front(), {24'd0, ddc_rdata}, {24'd0, d_exp.pop_front()});
    end
    if (csum_busy) busy_cyc++;
    if (csum_done) done_cnt++;
  end

  task automatic host_write(input logic [7:0] a, input logic [7:0] d, input bit accept);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    tick();
    host_we = 1'b0;
    if (accept) bmem[a] = d;
  endtask

  task automatic host_read(input logic [7:0] a, input string tag);
    h_exp.push_back(bmem[a]); h_tag.push_back(tag);
    host_rd = 1'b1; host_addr = a;
    tick();
    host_rd = 1'b0;
  endtask

  task automatic ddc_read(input logic [7:0] a, input logic p, input logic [7:0] e, input string tag);
    d_exp.push_back(e); d_tag.push_back(tag);
    ddc_rd = 1'b1; ddc_addr = a; ddc_port = p;
    tick();
    ddc_rd = 1'b0;
  endtask

  // model of a run: block checksums into bmem, per-port checksums into pcs
  task automatic model_run();
    for (int b = 0; b < 2; b++) begin
      logic [7:0] s = 8'd0;
      for (int i = 0; i < 127; i++) s = s + bmem[b*128+i];
      bmem[b*128+127] = 8'd0 - s;
    end
    if (paddr_loc > 8'h7F) begin
      for (int p = 0; p < 2; p++) begin
        logic [7:0] s = 8'd0;
        int base = {24'd0, paddr_loc[7], 7'd0};
        for (int i = 0; i < 127; i++) begin
          logic [7:0] a = 8'(base + i);
          if (a == paddr_loc)              s = s + port_paddr[p*16+8 +: 8];
          else if (a == paddr_loc + 8'd1)  s = s + port_paddr[p*16 +: 8];
          else                             s = s + bmem[a];
        end
        pcs[p] = 8'd0 - s;
      end
    end
  endtask

  task automatic run_engine(input string tag);
    busy_cyc = 0; done_cnt = 0;
    csum_start = 1'b1;
    tick();
    csum_start = 1'b0;
    chk({tag, " R4 busy after start"}, {31'd0, csum_busy}, 1);
    repeat (10) tick();
    csum_start = 1'b1;               // R5: ignored while busy
    tick();
    csum_start = 1'b0;
    host_write(8'h10, 8'h55, 1'b0);  // R2: discarded while busy
    while (csum_busy) tick();
    repeat (3) tick();
    chk({tag, " R4 busy length"}, busy_cyc, 256);
    chk({tag, " R5 single done pulse"}, done_cnt, 1);
    model_run();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired (R1..R11 incomplete)");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int wait_cyc;
    rst_n = 1'b0; host_we = 0; host_rd = 0; csum_start = 0; ddc_rd = 0;
    host_addr = 0; host_wdata = 0; ddc_addr = 0; ddc_port = 0;
    paddr_loc = 8'h9A; port_paddr = {16'h2100, 16'h1234};
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    pcs[0] = 0; pcs[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready low in reset", {31'd0, ready}, 0);
    chk("R4 busy low in reset", {31'd0, csum_busy}, 0);
    rst_n = 1'b1;
    wait_cyc = 0;
    repeat (20) begin tick(); wait_cyc++; end
    host_write(8'h02, 8'hAA, 1'b0);  // R2: before ready
    wait_cyc++;
    while (!ready && wait_cyc < 400) begin tick(); wait_cyc++; end
    chk("R1 ready within bound", {31'd0, (wait_cyc <= 260)}, 1);
    for (int i = 0; i < 256; i++) host_read(8'(i), "R1 cleared byte");
    host_read(8'h02, "R2 write before ready");

    for (int i = 0; i < 256; i++) host_write(8'(i), 8'((i*37 + 11) & 255), 1'b1);

    run_engine("run1");
    chk("R1 ready held", {31'd0, ready}, 1);
    host_read(8'h7F, "R6 block0 checksum");
    host_read(8'hFF, "R6 block1 checksum");
    host_read(8'h10, "R2 write during busy");
    host_read(8'h9A, "R3 raw byte at location");
    host_read(8'h9B, "R3 raw byte after location");

    ddc_read(8'h9A, 1'b0, 8'h12, "R8 port0 fields A,B");
    ddc_read(8'h9B, 1'b0, 8'h34, "R8 port0 fields C,D");
    ddc_read(8'hFF, 1'b0, pcs[0], "R9 port0 checksum");
    ddc_read(8'h7F, 1'b0, bmem[8'h7F], "R7 other block checksum");
    ddc_read(8'h20, 1'b0, bmem[8'h20], "R7 plain byte");
    ddc_read(8'h9A, 1'b1, 8'h21, "R11 port1 fields A,B");
    ddc_read(8'h9B, 1'b1, 8'h00, "R11 port1 fields C,D");
    ddc_read(8'hFF, 1'b1, pcs[1], "R11 port1 checksum");

    paddr_loc = 8'h40;
    ddc_read(8'h40, 1'b0, bmem[8'h40], "R10 low location raw");
    ddc_read(8'h41, 1'b1, bmem[8'h41], "R10 low location next raw");
    ddc_read(8'h7F, 1'b0, bmem[8'h7F], "R10 block0 checksum raw");
    ddc_read(8'hFF, 1'b1, bmem[8'hFF], "R10 block1 checksum raw");

    paddr_loc = 8'h80; port_paddr = {16'hABCD, 16'h3300};
    host_write(8'h85, 8'hC3, 1'b1);
    run_engine("run2");
    host_read(8'hFF, "R6 block1 checksum run2");
    ddc_read(8'h80, 1'b1, 8'hAB, "R8 boundary location port1");
    ddc_read(8'h81, 1'b1, 8'hCD, "R8 boundary next port1");
    ddc_read(8'hFF, 1'b1, pcs[1], "R9 boundary checksum port1");
    ddc_read(8'hFF, 1'b0, pcs[0], "R9 boundary checksum port0");
    ddc_read(8'h85, 1'b0, 8'hC3, "R7 plain byte run2");

    repeat (4) tick();
    chk("R3 host scoreboard drained", h_exp.size(), 0);
    chk("R7 ddc scoreboard drained", d_exp.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule